// File: doc/BRIEF.md
# Pixel-to-Bus Cycle Packer

This block sits between a pixel stream and a narrow parallel display data bus. Each pixel arrives right-aligned on a valid/ready input and is 12, 16, 18 or 24 bits wide. The block cuts it into words as wide as the selected bus, which has 8, 9, 12 or 16 lines. Each word leaves on a valid/ready output with a tag that marks it as display data. Two 2-bit selects give the pixel size and the bus width. From their ratio the block works out how many bus cycles each pixel takes: one, two or three cycles per pixel, or three cycles for every pair of pixels.

Pixel bits always leave most significant first. In the pair format the two pixels behave as one continuous bit stream:
- The first word holds the top bus-width bits of the first pixel.
- The middle word holds the last half-bus of the first pixel in its upper half and the first half-bus of the second pixel in its lower half.
- The last word holds the rest of the second pixel.

The output word is registered. A new pixel is taken only in the cycle that hands over the final word of the previous pixel, or when the output stage is empty. The selects are expected to change only while no transfer is in progress.

Top module: `pix_bus_packer`

## Requirements
- R1: While reset is high and in the first cycle after it, out_valid is 0. With a legal setting and an empty output stage, in_ready is 1. A reset in the middle of a pixel discards the rest of that pixel.
- R2: Pixel select codes 0,1,2,3 mean 12,16,18,24 bits. Bus select codes 0,1,2,3 mean 8,9,12,16 lines. When the two widths are equal (12/12, 16/16), each pixel gives exactly one word equal to the pixel.
- R3: When the pixel is twice the bus width (16/8, 18/9, 24/12), each pixel gives two words: the upper half first, then the lower half.
- R4: A 24-bit pixel on 8 lines gives three words: bits 23:16, then 15:8, then 7:0.
- R5: When the pixel is 1.5 times the bus width (12/8, 18/12, 24/16), pixels go in pairs over three words. With N the bus width:
  - Word 1 is the top N bits of the first pixel.
  - Word 2 is the low N/2 bits of the first pixel in its upper half, followed by the top N/2 bits of the second pixel in its lower half.
  - Word 3 is the low N bits of the second pixel.
- R6: Bus lines above the selected width are driven to 0 in every valid word.
- R7: Any other width pair is illegal. While it is selected, in_ready stays 0 and no word is produced.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_data holds its value.
- R9: A pixel is accepted only in a cycle where the output is empty or its word is being taken, and only when no word of the current pixel is still waiting behind the output. The number of words handed over before each accepted pixel matches the format: k·c words for pixel k at c cycles per pixel; in the pair format, 3·(k/2) words for an even k and 3·(k/2)+1 for an odd k.
- R10: Every valid output word has out_is_data set to 1.
- R11: Input bits above the selected pixel size have no effect on the output words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_pix_sel | input | 2 | Pixel size select (0=12, 1=16, 2=18, 3=24 bits) |
| cfg_bus_sel | input | 2 | Bus width select (0=8, 1=9, 2=12, 3=16 lines) |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can take the input pixel this cycle |
| in_pixel | input | PX_W | Pixel, right-aligned |
| out_valid | output | 1 | Output bus word valid |
| out_ready | input | 1 | Receiver takes the output word |
| out_data | output | BUS_W | Bus word, right-aligned, upper lines zero |
| out_is_data | output | 1 | Tag marking the word as display data |

## Verification
Two events can fall on the same clock edge:
- the hand-over of the final word of one pixel, and
- the acceptance of the next pixel, whose first word then loads at once into the output register.

In the pair format the same overlap also occurs when the first word of a pair is taken and the second pixel is pulled in to build the spliced middle word. The bench provokes these overlaps with continuous flow and with a repeating out_ready stall pattern in every format. At each acceptance it checks that the number of words already handed over matches the format. It checks that each stalled word reappears unchanged on the next cycle. It compares every word against a bit stream built from the pixels, most significant bit first.

// File: rtl/pk_pkg.sv
package pk_pkg;

  localparam int PX_MAX  = 24;
  localparam int BUS_MAX = 16;
  localparam int CNT_W   = $clog2(PX_MAX + 1);

  typedef enum logic [1:0] {
    FMT_ONE_PER_PX   = 2'd0,
    FMT_TWO_PER_PX   = 2'd1,
    FMT_THREE_PER_PX = 2'd2,
    FMT_THREE_PER_PAIR = 2'd3
  } cyc_fmt_e;

  typedef struct packed {
    logic             legal;
    cyc_fmt_e         fmt;
    logic [CNT_W-1:0] pix_bits;
    logic [CNT_W-1:0] bus_bits;
    logic [CNT_W-1:0] half_bits;   // first-pixel share of the spliced cycle
    logic [1:0]       words_per_px;
  } fmt_cfg_t;

endpackage

// File: rtl/pk_fmt_decode.sv
module pk_fmt_decode
  import pk_pkg::*;
(
  input  logic [1:0] pix_sel,
  input  logic [1:0] bus_sel,
  output fmt_cfg_t   cfg
);

  logic [CNT_W-1:0] pb, bb;
  logic [CNT_W+1:0] p1, p2, b1, b2, b3;

  always_comb begin
    case (pix_sel)
      2'd0:    pb = CNT_W'(12);
      2'd1:    pb = CNT_W'(16);
      2'd2:    pb = CNT_W'(18);
      default: pb = CNT_W'(24);
    endcase
    case (bus_sel)
      2'd0:    bb = CNT_W'(8);
      2'd1:    bb = CNT_W'(9);
      2'd2:    bb = CNT_W'(12);
      default: bb = CNT_W'(16);
    endcase
  end

  assign p1 = {2'b00, pb};
  assign p2 = {1'b0, pb, 1'b0};
  assign b1 = {2'b00, bb};
  assign b2 = {1'b0, bb, 1'b0};
  assign b3 = b1 + b2;

  always_comb begin
    cfg.pix_bits     = pb;
    cfg.bus_bits     = bb;
    cfg.half_bits    = bb >> 1;
    cfg.legal        = 1'b1;
    cfg.fmt          = FMT_ONE_PER_PX;
    cfg.words_per_px = 2'd1;
    if (p1 == b1) begin
      cfg.fmt          = FMT_ONE_PER_PX;
      cfg.words_per_px = 2'd1;
    end else if (p1 == b2) begin
      cfg.fmt          = FMT_TWO_PER_PX;
      cfg.words_per_px = 2'd2;
    end else if (p1 == b3) begin
      cfg.fmt          = FMT_THREE_PER_PX;
      cfg.words_per_px = 2'd3;
    end else if (p2 == b3) begin
      cfg.fmt          = FMT_THREE_PER_PAIR;
      cfg.words_per_px = 2'd1;
    end else begin
      cfg.legal = 1'b0;
    end
  end

endmodule

// File: rtl/pk_align.sv
module pk_align
  import pk_pkg::*;
#(
  parameter int PX_W = PX_MAX
) (
  input  logic [PX_W-1:0]  raw_px,
  input  logic [CNT_W-1:0] px_bits,
  output logic [PX_W-1:0]  msb_px
);

  // Left-justify so the pixel MSB sits at bit PX_W-1; stray upper bits fall off.
  assign msb_px = raw_px << (CNT_W'(PX_W) - px_bits);

endmodule

// File: rtl/pk_seq.sv
module pk_seq
  import pk_pkg::*;
#(
  parameter int PX_W  = PX_MAX,
  parameter int BUS_W = BUS_MAX
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             legal,
  input  logic             pair_fmt,
  input  logic [CNT_W-1:0] bus_bits,
  input  logic [CNT_W-1:0] half_bits,
  input  logic [1:0]       words_per_px,
  input  logic             px_valid,
  input  logic [PX_W-1:0]  px_msb,
  output logic             px_ready,
  output logic             wd_valid,
  input  logic             wd_ready,
  output logic [BUS_W-1:0] wd_data,
  output logic             wd_tag
);

  logic [PX_W-1:0]  sh_q, sh_n;
  logic [1:0]       left_q, left_n;
  logic             half_q, half_n;
  logic             vld_n;
  logic [BUS_W-1:0] data_n;
  logic [PX_W-1:0]  word;
  logic             free, take_px;

  function automatic logic [PX_W-1:0] take_top(input logic [PX_W-1:0] v,
                                               input logic [CNT_W-1:0] n);
    return v >> (CNT_W'(PX_W) - n);
  endfunction

  assign free     = !wd_valid || wd_ready;
  assign px_ready = legal && free && (left_q == 2'd0);
  assign take_px  = px_ready && px_valid;

  always_comb begin
    sh_n   = sh_q;
    left_n = left_q;
    half_n = half_q;
    vld_n  = wd_valid;
    word   = '0;
    data_n = wd_data;
    if (free) begin
      if (left_q != 2'd0) begin
        word   = take_top(sh_q, bus_bits);
        sh_n   = sh_q << bus_bits;
        left_n = left_q - 2'd1;
        vld_n  = 1'b1;
      end else if (take_px) begin
        vld_n = 1'b1;
        if (half_q) begin
          word   = (take_top(sh_q, half_bits) << half_bits) | take_top(px_msb, half_bits);
          sh_n   = px_msb << half_bits;
          left_n = 2'd1;
          half_n = 1'b0;
        end else begin
          word = take_top(px_msb, bus_bits);
          sh_n = px_msb << bus_bits;
          if (pair_fmt) begin
            left_n = 2'd0;
            half_n = 1'b1;
          end else begin
            left_n = words_per_px - 2'd1;
          end
        end
      end else begin
        vld_n = 1'b0;
      end
      if (vld_n) data_n = word[BUS_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q     <= '0;
      left_q   <= '0;
      half_q   <= 1'b0;
      wd_valid <= 1'b0;
      wd_data  <= '0;
      wd_tag   <= 1'b0;
    end else begin
      sh_q     <= sh_n;
      left_q   <= left_n;
      half_q   <= half_n;
      wd_valid <= vld_n;
      wd_data  <= data_n;
      wd_tag   <= vld_n;
    end
  end

endmodule

// File: rtl/pix_bus_packer.sv
module pix_bus_packer
  import pk_pkg::*;
#(
  parameter int PX_W  = PX_MAX,
  parameter int BUS_W = BUS_MAX
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cfg_pix_sel,
  input  logic [1:0]       cfg_bus_sel,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PX_W-1:0]  in_pixel,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [BUS_W-1:0] out_data,
  output logic             out_is_data
);

  fmt_cfg_t        cfg;
  logic [PX_W-1:0] px_msb;

  pk_fmt_decode u_dec (
    .pix_sel (cfg_pix_sel),
    .bus_sel (cfg_bus_sel),
    .cfg     (cfg)
  );

  pk_align #(.PX_W(PX_W)) u_align (
    .raw_px  (in_pixel),
    .px_bits (cfg.pix_bits),
    .msb_px  (px_msb)
  );

  pk_seq #(.PX_W(PX_W), .BUS_W(BUS_W)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .legal        (cfg.legal),
    .pair_fmt     (cfg.fmt == FMT_THREE_PER_PAIR),
    .bus_bits     (cfg.bus_bits),
    .half_bits    (cfg.half_bits),
    .words_per_px (cfg.words_per_px),
    .px_valid     (in_valid),
    .px_msb       (px_msb),
    .px_ready     (in_ready),
    .wd_valid     (out_valid),
    .wd_ready     (out_ready),
    .wd_data      (out_data),
    .wd_tag       (out_is_data)
  );

endmodule

// File: rtl/pix_bus_packer_chk.sv
module pix_bus_packer_chk #(
  parameter int PX_W  = 24,
  parameter int BUS_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       cfg_pix_sel,
  input logic [1:0]       cfg_bus_sel,
  input logic             in_valid,
  input logic             in_ready,
  input logic [PX_W-1:0]  in_pixel,
  input logic             out_valid,
  input logic             out_ready,
  input logic [BUS_W-1:0] out_data,
  input logic             out_is_data
);

  // R8: a stalled word is held unchanged
  a_r8_hold_stall: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R9: a pixel is only taken when the output stage can move
  a_r9_ready_gated: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (!out_valid || out_ready));

  // R6: eight-line bus leaves upper lines at zero
  a_r6_upper_zero: assert property (@(posedge clk) disable iff (rst)
    out_valid && cfg_bus_sel == 2'd0 |-> (out_data >> 8) == '0);

  // R10: each valid word is tagged as data
  a_r10_tag: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_is_data);

  // R7: 12-bit pixels on a 9-line bus are never taken
  a_r7_illegal: assert property (@(posedge clk) disable iff (rst)
    cfg_pix_sel == 2'd0 && cfg_bus_sel == 2'd1 |-> !in_ready);

  // R4: first word of a 24-bit pixel on 8 lines is its top byte
  a_r4_first_byte: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && cfg_pix_sel == 2'd3 && cfg_bus_sel == 2'd0
    |=> out_valid && out_data == BUS_W'($past(in_pixel[23:16])));

endmodule

bind pix_bus_packer pix_bus_packer_chk #(.PX_W(PX_W), .BUS_W(BUS_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_pix_sel (cfg_pix_sel),
  .cfg_bus_sel (cfg_bus_sel),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_pixel    (in_pixel),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .out_is_data (out_is_data)
);

// File: tb/tb_pix_bus_packer.sv
`timescale 1ns/1ps
module tb_pix_bus_packer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cfg_pix_sel = 2'd0;
  logic [1:0]  cfg_bus_sel = 2'd2;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] in_pixel = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_data;
  logic        out_is_data;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 0;

  logic [23:0] px_a [8];
  logic [15:0] exp_w [24];

  always #2 clk = ~clk;

  pix_bus_packer dut (
    .clk(clk), .rst(rst), .cfg_pix_sel(cfg_pix_sel), .cfg_bus_sel(cfg_bus_sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_pixel(in_pixel),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_is_data(out_is_data)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int pbits(input logic [1:0] s);
    case (s) 2'd0: return 12; 2'd1: return 16; 2'd2: return 18; default: return 24; endcase
  endfunction

  function automatic int bbits(input logic [1:0] s);
    case (s) 2'd0: return 8; 2'd1: return 9; 2'd2: return 12; default: return 16; endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  // Streams npix pixels in format (ps,bs) and compares every word with an MSB-first bit stream.
  task automatic run_case(input logic [1:0] ps, input logic [1:0] bs, input int npix,
                          input bit bp, input bit junk, input string req);
    int psz = pbits(ps);
    int bwd = bbits(bs);
    int nw  = npix * psz / bwd;
    bit pair = (2 * psz == 3 * bwd);
    logic [191:0] st = '0;
    int pi = 0, wi = 0, it = 0;
    bit stall_q = 0;
    logic [15:0] stall_d = '0;
    @(negedge clk);
    cfg_pix_sel = ps; cfg_bus_sel = bs;
    for (int i = 0; i < npix; i++) begin
      logic [23:0] m = (24'd1 << psz) - 24'd1;
      px_a[i] = (24'h5A3C96 ^ (24'(i) * 24'h1F2E3D) ^ {ps, bs, 20'h0});
      if (!junk) px_a[i] = px_a[i] & m;
      st = (st << psz) | 192'(px_a[i] & m);
    end
    for (int k = 0; k < nw; k++)
      exp_w[k] = 16'((st >> (npix * psz - (k + 1) * bwd)) & ((192'd1 << bwd) - 192'd1));
    while ((wi < nw) && (it < 400)) begin
      in_valid  = (pi < npix);
      in_pixel  = (pi < npix) ? px_a[pi] : '0;
      out_ready = bp ? ((it % 3) != 1) : 1'b1;
      #1;
      if (stall_q) begin
        check(out_valid === 1'b1 && out_data === stall_d, "R8 held word", out_data, stall_d);
      end
      stall_q = out_valid && !out_ready;
      stall_d = out_data;
      if (out_valid && out_ready) begin
        check(out_data === exp_w[wi], req, out_data, exp_w[wi]);
        check(out_is_data === 1'b1, "R10 data tag", out_is_data, 1);
        if (bwd == 8) check((out_data >> 8) == 0, "R6 upper lines zero", out_data, exp_w[wi]);
        wi++;
      end
      if (in_valid && in_ready) begin
        int expw = pair ? ((pi / 2) * 3 + (pi % 2)) : pi * (psz / bwd);
        check(wi == expw, "R9 words before accept", wi, expw);
        pi++;
      end
      it++;
      @(negedge clk);
    end
    in_valid = 1'b0; out_ready = 1'b1;
    check(wi == nw, {req, " word count"}, wi, nw);
    check(pi == npix, "R9 pixel count", pi, npix);
    @(negedge clk);
    check(out_valid === 1'b0, "R9 idle after drain", out_valid, 0);
  endtask

  task automatic t_reset();
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
    cfg_pix_sel = 2'd0; cfg_bus_sel = 2'd2;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R1 valid in reset", out_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid === 1'b0, "R1 valid after reset", out_valid, 0);
    check(in_ready === 1'b1, "R1 ready after reset", in_ready, 1);
  endtask

  task automatic t_illegal(input logic [1:0] ps, input logic [1:0] bs);
    @(negedge clk);
    cfg_pix_sel = ps; cfg_bus_sel = bs;
    in_valid = 1'b1; in_pixel = 24'hABCDEF; out_ready = 1'b1;
    for (int i = 0; i < 6; i++) begin
      #1;
      check(in_ready === 1'b0, "R7 no accept", in_ready, 0);
      check(out_valid === 1'b0, "R7 no word", out_valid, 0);
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic t_mid_reset();
    @(negedge clk);
    cfg_pix_sel = 2'd3; cfg_bus_sel = 2'd0;
    in_valid = 1'b1; in_pixel = 24'h112233; out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1 && out_data === 16'h0011, "R4 first byte", out_data, 16'h0011);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(out_valid === 1'b0, "R1 mid-pixel reset", out_valid, 0);
    in_valid = 1'b1; in_pixel = 24'hC4D5E6; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_data === 16'h00C4, "R1 fresh pixel after reset", out_data, 16'h00C4);
    @(negedge clk);
    check(out_data === 16'h00D5, "R4 second byte", out_data, 16'h00D5);
    @(negedge clk);
    check(out_data === 16'h00E6, "R4 third byte", out_data, 16'h00E6);
    @(negedge clk);
    check(out_valid === 1'b0, "R4 three words only", out_valid, 0);
  endtask

  task automatic t_pair_explicit();
    @(negedge clk);
    cfg_pix_sel = 2'd3; cfg_bus_sel = 2'd3; out_ready = 1'b1;
    in_valid = 1'b1; in_pixel = 24'hABCDEF;
    @(negedge clk);
    check(out_data === 16'hABCD, "R5 word one", out_data, 16'hABCD);
    in_pixel = 24'h123456;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_data === 16'hEF12, "R5 spliced word", out_data, 16'hEF12);
    @(negedge clk);
    check(out_data === 16'h3456, "R5 word three", out_data, 16'h3456);
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    run_case(2'd0, 2'd2, 5, 0, 0, "R2 12 on 12");
    run_case(2'd1, 2'd3, 5, 1, 0, "R2 16 on 16");
    run_case(2'd1, 2'd0, 4, 0, 0, "R3 16 on 8");
    run_case(2'd2, 2'd1, 4, 1, 0, "R3 18 on 9");
    run_case(2'd3, 2'd2, 4, 0, 0, "R3 24 on 12");
    run_case(2'd3, 2'd0, 4, 1, 0, "R4 24 on 8");
    run_case(2'd0, 2'd0, 6, 0, 1, "R11 R5 12 on 8 junk upper bits");
    run_case(2'd2, 2'd2, 4, 1, 1, "R11 R5 18 on 12 junk upper bits");
    run_case(2'd3, 2'd3, 8, 1, 0, "R5 24 on 16");
    t_pair_explicit();
    t_illegal(2'd0, 2'd1);
    t_illegal(2'd1, 2'd2);
    t_illegal(2'd0, 2'd3);
    t_mid_reset();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule